// File: doc/BRIEF.md
# Alarm Status and Interrupt Controller

This block collects eight receive-side alarm and error conditions into a latched status register. It masks them with a host-written enable register and drives a single active-low interrupt line to a host processor. Each condition arrives as a level that has already been synchronised. While the level is high, the matching status bit is set on every clock.

The host reaches the block through a small synchronous register port. The port has a one-bit address, a read strobe, a write strobe, a write data bus and a burst qualifier on reads. Status can be read in two ways. A burst read only observes the status. A direct read also clears every latched bit whose condition has gone away. The mask register is read and written at its own address.

An access decoder is built as a named-state machine. In each cycle the strobes select one access state: `HOST_IDLE`, `HOST_RD_BURST`, `HOST_RD_DIRECT`, `HOST_RD_MASK`, `HOST_WR_MASK` or `HOST_WR_IGNORED`. The transition into a state happens at the edge that performs that access. From any state, the next state depends only on the strobes of the current cycle: a write beats a read, and no strobe leads to `HOST_IDLE`. The registered state drives the read-valid output, and the output process loads the read data.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: Synchronous reset (rst high at a clock edge) clears the status register and the mask register to 0. After reset irq_n is 1 and host_rvalid is 0.
- R2: Status and mask bit positions, from bit 7 down to bit 0, are: remote alarm, distant multiframe alarm, signalling all ones, unframed all ones, frame resync criteria met, multiframe resync criteria met, loss of sync, error count saturation. cond_i[k] drives status bit k.
- R3: If cond_i[k] is 1 in a cycle, status bit k is 1 after that clock edge. Setting takes priority over any clear in the same cycle.
- R4: A read at address 0 with host_burst=1 returns the status and leaves every status bit unchanged.
- R5: A read at address 0 with host_burst=0 returns the status value held before that edge. After the edge, each status bit equals cond_i of the read cycle, so latched bits whose condition is inactive are cleared.
- R6: A write at address 1 loads host_wdata into the mask. A read at address 1 returns exactly the value last written, whatever host_burst is.
- R7: irq_n is registered and active low. After each edge it is 0 exactly when some bit is 1 in both the status and the mask as they stand after that edge.
- R8: A mask bit written to 0 removes that bit's interrupt contribution from the same edge that loads the mask, whatever the status bit holds.
- R9: Read data is valid one edge after the read strobe, marked by a one-cycle host_rvalid pulse, and is held until the next accepted read. When host_wr and host_rd are both 1, only the write is performed.
- R10: A write at address 0 changes neither the status nor the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cond_i | input | 8 | Synchronised condition levels, bit order as in R2 |
| host_addr | input | 1 | 0 = status, 1 = mask |
| host_rd | input | 1 | Read strobe, one access per cycle |
| host_wr | input | 1 | Write strobe |
| host_burst | input | 1 | 1 marks a read as burst (non-clearing) |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| host_rvalid | output | 1 | One-cycle pulse when host_rdata is new |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The directed part brings a condition up while the mask is zero, then enables the mask. This shows the mask gating apart from the status latch. It then reads with the condition still active, and again after it drops, to tell burst from direct reads and set-priority from clearing. Further cases write a mask bit to zero while status is latched, issue a read and a write together, and write to the status address. Each of these separates the intended path from a plausible wrong one. A long random run then mixes sparse condition pulses with random strobes and compares the interrupt and read data every cycle against a bench model of the status and mask.

// File: rtl/alarm_irq_pkg.sv
`timescale 1ns/1ps
package alarm_irq_pkg;
    localparam int NUM_COND = 8;

    // Register map: one address bit selects status or mask
    localparam logic ADDR_STATUS = 1'b0;
    localparam logic ADDR_MASK   = 1'b1;

    typedef logic [NUM_COND-1:0] cond_vec_t;

    typedef enum logic [2:0] {
        HOST_IDLE       = 3'd0,
        HOST_RD_BURST   = 3'd1,
        HOST_RD_DIRECT  = 3'd2,
        HOST_RD_MASK    = 3'd3,
        HOST_WR_MASK    = 3'd4,
        HOST_WR_IGNORED = 3'd5
    } host_state_t;
endpackage

// File: rtl/alarm_host_fsm.sv
`timescale 1ns/1ps
module alarm_host_fsm
    import alarm_irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        host_addr,
    input  logic        host_rd,
    input  logic        host_wr,
    input  logic        host_burst,
    input  cond_vec_t   status_q,
    input  cond_vec_t   mask_q,
    output host_state_t access,
    output logic        clr_direct,
    output logic        mask_we,
    output cond_vec_t   host_rdata,
    output logic        host_rvalid
);
    host_state_t state_q;
    cond_vec_t   rdata_q;

    // Transition selection: write beats read, no strobe means idle
    always_comb begin
        access = HOST_IDLE;
        if (host_wr) begin
            access = (host_addr == ADDR_MASK) ? HOST_WR_MASK : HOST_WR_IGNORED;
        end else if (host_rd) begin
            if (host_addr == ADDR_MASK)
                access = HOST_RD_MASK;
            else if (host_burst)
                access = HOST_RD_BURST;
            else
                access = HOST_RD_DIRECT;
        end
    end

    assign clr_direct = (access == HOST_RD_DIRECT);
    assign mask_we    = (access == HOST_WR_MASK);

    // State register
    always_ff @(posedge clk) begin
        if (rst)
            state_q <= HOST_IDLE;
        else
            state_q <= access;
    end

    // Output process: read data captured at the access edge
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else begin
            unique case (access)
                HOST_RD_BURST,
                HOST_RD_DIRECT:  rdata_q <= status_q;
                HOST_RD_MASK:    rdata_q <= mask_q;
                HOST_IDLE,
                HOST_WR_MASK,
                HOST_WR_IGNORED: rdata_q <= rdata_q;
                default:         rdata_q <= rdata_q;
            endcase
        end
    end

    assign host_rdata  = rdata_q;
    assign host_rvalid = (state_q == HOST_RD_BURST) || (state_q == HOST_RD_DIRECT) ||
                         (state_q == HOST_RD_MASK);

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_rd) |=> !host_rvalid); // R9
    AST_RDATA_HELD: assert property (@(posedge clk) disable iff (rst)
        !host_rd |=> $stable(host_rdata)); // R9
endmodule

// File: rtl/alarm_status_reg.sv
`timescale 1ns/1ps
module alarm_status_reg
    import alarm_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  cond_vec_t cond_i,
    input  logic      clr_direct,
    input  logic      burst_rd,
    output cond_vec_t status_nxt,
    output cond_vec_t status_q
);
    // One cell per condition; set wins over the direct-read clear
    for (genvar i = 0; i < NUM_COND; i++) begin : g_cell
        always_comb status_nxt[i] = cond_i[i] | (status_q[i] & ~clr_direct);

        always_ff @(posedge clk) begin
            if (rst)
                status_q[i] <= 1'b0;
            else
                status_q[i] <= status_nxt[i];
        end
    end

    AST_SET_ON_COND: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status_q & $past(cond_i)) == $past(cond_i))); // R3
    AST_BURST_NO_DROP: assert property (@(posedge clk) disable iff (rst)
        burst_rd |=> (($past(status_q) & ~status_q) == '0)); // R4
    AST_DIRECT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        clr_direct |=> (status_q == $past(cond_i))); // R5
endmodule

// File: rtl/alarm_mask_reg.sv
`timescale 1ns/1ps
module alarm_mask_reg
    import alarm_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      mask_we,
    input  cond_vec_t wdata,
    output cond_vec_t mask_nxt,
    output cond_vec_t mask_q
);
    always_comb mask_nxt = mask_we ? wdata : mask_q;

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '0;
        else
            mask_q <= mask_nxt;
    end

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
        mask_we |=> (mask_q == $past(wdata))); // R6
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !mask_we |=> $stable(mask_q)); // R10
endmodule

// File: rtl/alarm_irq_gen.sv
`timescale 1ns/1ps
module alarm_irq_gen
    import alarm_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  cond_vec_t status_nxt,
    input  cond_vec_t mask_nxt,
    output logic      irq_n
);
    // Registered from next-state values so the line tracks the registers
    always_ff @(posedge clk) begin
        if (rst)
            irq_n <= 1'b1;
        else
            irq_n <= ~|(status_nxt & mask_nxt);
    end
endmodule

// File: rtl/alarm_irq_ctrl.sv
`timescale 1ns/1ps
module alarm_irq_ctrl
    import alarm_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_COND-1:0] cond_i,
    input  logic                host_addr,
    input  logic                host_rd,
    input  logic                host_wr,
    input  logic                host_burst,
    input  logic [NUM_COND-1:0] host_wdata,
    output logic [NUM_COND-1:0] host_rdata,
    output logic                host_rvalid,
    output logic                irq_n
);
    host_state_t access;
    logic        clr_direct;
    logic        mask_we;
    cond_vec_t   status_q, status_nxt;
    cond_vec_t   mask_q, mask_nxt;

    alarm_host_fsm u_host (
        .clk        (clk),
        .rst        (rst),
        .host_addr  (host_addr),
        .host_rd    (host_rd),
        .host_wr    (host_wr),
        .host_burst (host_burst),
        .status_q   (status_q),
        .mask_q     (mask_q),
        .access     (access),
        .clr_direct (clr_direct),
        .mask_we    (mask_we),
        .host_rdata (host_rdata),
        .host_rvalid(host_rvalid)
    );

    alarm_status_reg u_status (
        .clk        (clk),
        .rst        (rst),
        .cond_i     (cond_i),
        .clr_direct (clr_direct),
        .burst_rd   (access == HOST_RD_BURST),
        .status_nxt (status_nxt),
        .status_q   (status_q)
    );

    alarm_mask_reg u_mask (
        .clk     (clk),
        .rst     (rst),
        .mask_we (mask_we),
        .wdata   (host_wdata),
        .mask_nxt(mask_nxt),
        .mask_q  (mask_q)
    );

    alarm_irq_gen u_irq (
        .clk       (clk),
        .rst       (rst),
        .status_nxt(status_nxt),
        .mask_nxt  (mask_nxt),
        .irq_n     (irq_n)
    );

    AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_n == ~|(status_q & mask_q))); // R7
    AST_MASK_ZERO_QUIET: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr == ADDR_MASK && host_wdata == '0) |=> irq_n); // R8
endmodule

// File: tb/alarm_irq_ctrl_tb.sv
`timescale 1ns/1ps
module alarm_irq_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] cond_i;
    logic       host_addr, host_rd, host_wr, host_burst;
    logic [7:0] host_wdata;
    logic [7:0] host_rdata;
    logic       host_rvalid;
    logic       irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] m_status, m_mask, m_rdata;
    logic       m_rvalid;

    always #4 clk = ~clk;

    alarm_irq_ctrl u_dut (
        .clk(clk), .rst(rst), .cond_i(cond_i), .host_addr(host_addr),
        .host_rd(host_rd), .host_wr(host_wr), .host_burst(host_burst),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_rvalid(host_rvalid), .irq_n(irq_n)
    );

    function automatic logic exp_irq(input logic [7:0] st, input logic [7:0] mk);
        return ~|(st & mk);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One host cycle; model updated at the edge, outputs checked 1 ns after
    task automatic step(input logic rd, input logic wr, input logic addr,
                        input logic burst, input logic [7:0] wd, input logic [7:0] cnd,
                        input string req);
        logic       do_wr, do_rd;
        @(negedge clk);
        host_rd = rd; host_wr = wr; host_addr = addr;
        host_burst = burst; host_wdata = wd; cond_i = cnd;
        do_wr = wr;
        do_rd = rd && !wr;
        @(posedge clk);
        m_rvalid = do_rd;
        if (do_rd) m_rdata = addr ? m_mask : m_status;
        if (do_wr && addr) m_mask = wd;
        m_status = ((do_rd && !addr && !burst) ? 8'h00 : m_status) | cnd;
        #1;
        check({req, " irq_n (R7)"}, 32'(irq_n), 32'(exp_irq(m_status, m_mask)));
        check({req, " rvalid (R9)"}, 32'(host_rvalid), 32'(m_rvalid));
        check({req, " rdata (R9)"}, 32'(host_rdata), 32'(m_rdata));
    endtask

    task automatic read_status_burst(input logic [7:0] cnd, input string req);
        step(1'b1, 1'b0, 1'b0, 1'b1, 8'h00, cnd, req);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd24681));
        rst = 1'b1; cond_i = '0; host_addr = 0; host_rd = 0; host_wr = 0;
        host_burst = 0; host_wdata = '0;
        m_status = '0; m_mask = '0; m_rdata = '0; m_rvalid = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 irq_n after reset", 32'(irq_n), 32'd1);
        check("R1 rvalid after reset", 32'(host_rvalid), 32'd0);
        @(negedge clk); rst = 1'b0;

        // R1: status and mask are zero
        read_status_burst(8'h00, "R1 status zero");
        step(1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, "R1 mask zero");

        // R2/R3: loss-of-sync (bit 1) latches while masked; no interrupt
        step(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h02, "R3 set while masked");
        step(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, "R3 latched");
        read_status_burst(8'h00, "R2 bit1 loss of sync");
        check("R2 status bit 1", 32'(host_rdata), 32'h02);

        // R6/R7: enable that bit, interrupt asserts
        step(1'b0, 1'b1, 1'b1, 1'b0, 8'h02, 8'h00, "R6 write mask");
        check("R7 irq low after enable", 32'(irq_n), 32'd0);
        step(1'b1, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00, "R6 mask readback");
        check("R6 mask readback value", 32'(host_rdata), 32'h02);

        // R4: burst read leaves the bit set
        read_status_burst(8'h00, "R4 burst read");
        read_status_burst(8'h00, "R4 still set");
        check("R4 bit survives burst", 32'(host_rdata), 32'h02);

        // R5: direct read with condition active keeps bit (set priority)
        step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h02, "R5 direct active");
        check("R5 pre-clear value", 32'(host_rdata), 32'h02);
        check("R3 set beats clear irq", 32'(irq_n), 32'd0);
        // R5: direct read after condition gone clears it
        step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, "R5 direct clears");
        check("R5 irq released", 32'(irq_n), 32'd1);

        // R2: remote alarm (bit 7) and error count saturation (bit 0)
        step(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h81, "R2 bits 7 and 0");
        step(1'b0, 1'b1, 1'b1, 1'b0, 8'h81, 8'h00, "R2 enable 7 and 0");
        check("R2 irq from bits 7/0", 32'(irq_n), 32'd0);

        // R8: writing 0 to mask kills interrupt at once, status stays
        step(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, "R8 mask cleared");
        check("R8 irq high same edge", 32'(irq_n), 32'd1);
        read_status_burst(8'h00, "R8 status kept");
        check("R8 status unchanged", 32'(host_rdata), 32'h81);

        // R9: read and write together; read not performed, status not cleared
        step(1'b1, 1'b1, 1'b0, 1'b0, 8'h5A, 8'h00, "R9 rd+wr same cycle");
        check("R9 no rvalid on conflict", 32'(host_rvalid), 32'd0);
        // R10: write at status address ignored
        step(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, "R10 write status addr");
        read_status_burst(8'h00, "R10 status intact");
        check("R10 status after writes", 32'(host_rdata), 32'h81);
        step(1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, "R10 mask intact");
        check("R10 mask after writes", 32'(host_rdata), 32'h00);

        // Random phase: sparse conditions, mixed accesses
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] cnd;
            logic [3:0] op;
            cnd = '0;
            for (int b = 0; b < 8; b++)
                if ($urandom_range(0, 15) == 0) cnd[b] = 1'b1;
            op = 4'($urandom_range(0, 15));
            step(op[0] & op[1], op[2] & op[3] & op[0], 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)), 8'($urandom), cnd, "R5 R4 R7 random");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule